// File: doc/BRIEF.md
# I2C Stuck-Bus Recovery Sequencer

This block frees an I2C bus that a slave is holding with SDA low after its transfer was cut short. On a trigger, if the bus is marked busy or SDA reads low, the sequencer takes the SCL and SDA pins from the normal controller. It releases SDA and clocks SCL as an open-drain output until the slave lets go of SDA or a pulse limit is reached. It then leaves SCL released high for one more half-period and hands both pins back.

Both pins use open-drain enables, where 1 pulls the line low. While the sequencer is idle the controller's enables pass straight through to the pads. The half-period is a parameter in input clock cycles. The default of 100000 cycles gives about 1 ms at 100 MHz. The pulse limit is also a parameter, with a default of 10. When a recovery ends, or when a trigger finds a clean bus, the host gets a one-cycle done strobe. A one-cycle failure flag comes with it if SDA was still low after the last allowed pulse.

Top module: `i2c_bus_unstick`

## Requirements
- R1: While no recovery is active (`owned`=0), `sclOe` equals `ctrlSclOe` and `sdaOe` equals `ctrlSdaOe`.
- R2: A `start` pulse seen while `busBusy`=0 and `sdaIn`=1 does not take the pins. `done` is 1 in the following cycle, and `failed` is 0.
- R3: A `start` pulse seen while `busBusy`=1 or `sdaIn`=0 sets `owned`=1 from the next cycle. The sequencer then drives SCL low (`sclOe`=1) for HALF_CYC cycles. For as long as `owned`=1, `sdaOe` is 0, whatever `ctrlSdaOe` is.
- R4: Each recovery pulse is HALF_CYC cycles of SCL released (`sclOe`=0) followed by HALF_CYC cycles of SCL driven low.
- R5: SDA is sampled in the last cycle of every low phase, including the first one. If it reads 1, no further pulse is issued.
- R6: No more than MAX_PULSES pulses are issued in one recovery, even if SDA stays low.
- R7: After the last low phase, SCL stays released for HALF_CYC cycles with `owned`=1. Then `owned` returns to 0. Total ownership is (2 + 2·n)·HALF_CYC cycles for n pulses.
- R8: `done` is high for exactly one cycle, in the first cycle with `owned`=0 after a recovery. `failed` is high in that cycle only when SDA was still low after MAX_PULSES pulses. `failed` is never high without `done`.
- R9: A `start` pulse during a recovery has no effect: the ownership length and pulse count stay as they would be without it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Recovery request, one cycle |
| busBusy | input | 1 | Bus-busy flag from the controller |
| sdaIn | input | 1 | Sampled SDA line level |
| ctrlSclOe | input | 1 | Controller's SCL pull-low enable |
| ctrlSdaOe | input | 1 | Controller's SDA pull-low enable |
| sclOe | output | 1 | SCL pad pull-low enable |
| sdaOe | output | 1 | SDA pad pull-low enable |
| owned | output | 1 | Sequencer holds the pins |
| done | output | 1 | One-cycle end-of-request strobe |
| failed | output | 1 | One-cycle flag: SDA still low at the limit |

## Verification
A slave model holds SDA low until it has seen a chosen number of SCL rising edges. That number is swept over 0, 1, 3, 5, one below and at the pulse limit, just past it, and never. These cases separate exit on release from exit on the limit, and the off-by-one cases show whether SDA is sampled before or after the pulse that frees it. A trigger that comes only from the busy flag checks the zero-pulse path. A trigger on a clean bus, a second trigger during a recovery, and idle pass-through patterns check that the pins are taken only when they should be.

// File: rtl/i2c_bus_unstick_pkg.sv
package i2c_bus_unstick_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW_INIT,
    ST_HIGH,
    ST_LOW,
    ST_PARK
  } seqState_t;

  typedef struct packed {
    logic loadTimer;
    logic clrPulse;
    logic incPulse;
    logic driveScl;
    logic own;
  } seqStrobe_t;
endpackage

// File: rtl/i2c_bus_unstick_dp.sv
module i2c_bus_unstick_dp
  import i2c_bus_unstick_pkg::*;
#(
  parameter int HALF_CYC   = 100000,
  parameter int MAX_PULSES = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strobe,
  input  logic       ctrlSclOe,
  input  logic       ctrlSdaOe,
  output logic       timerZero,
  output logic       pulseMax,
  output logic       sclOe,
  output logic       sdaOe
);
  localparam int TW = (HALF_CYC > 2) ? $clog2(HALF_CYC) : 1;
  localparam int PW = $clog2(MAX_PULSES + 1);
  localparam logic [TW-1:0] T_LOAD = TW'(HALF_CYC - 1);
  localparam logic [PW-1:0] P_MAX  = PW'(MAX_PULSES);

  logic [TW-1:0] timer;
  logic [PW-1:0] pulseCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timer <= '0;
    end else if (strobe.loadTimer) begin
      timer <= T_LOAD;
    end else if (timer != '0) begin
      timer <= timer - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseCnt <= '0;
    end else if (strobe.clrPulse) begin
      pulseCnt <= '0;
    end else if (strobe.incPulse) begin
      pulseCnt <= pulseCnt + 1'b1;
    end
  end

  assign timerZero = (timer == '0);
  assign pulseMax  = (pulseCnt == P_MAX);

  always_comb begin
    if (strobe.own) begin
      sclOe = strobe.driveScl;
      sdaOe = 1'b0;
    end else begin
      sclOe = ctrlSclOe;
      sdaOe = ctrlSdaOe;
    end
  end

  // R6: the control never asks for a pulse once the limit is reached
  a_r6_no_extra_pulse: assert property (@(posedge clk) disable iff (!rstN)
    strobe.incPulse |-> (pulseCnt < P_MAX));
  // R6: the counter stays within the limit
  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    pulseCnt <= P_MAX);
  // R4: a phase may only advance when its timer has expired
  a_r4_phase_len: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.own && !timerZero) |-> !strobe.loadTimer);
endmodule

// File: rtl/i2c_bus_unstick_ctrl.sv
module i2c_bus_unstick_ctrl
  import i2c_bus_unstick_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       busBusy,
  input  logic       sdaIn,
  input  logic       timerZero,
  input  logic       pulseMax,
  output seqStrobe_t strobe,
  output logic       owned,
  output logic       done,
  output logic       failed
);
  seqState_t state, stateNxt;
  logic      failPend, failPendNxt;
  logic      doneNxt, failedNxt;
  logic      lowPhase;

  assign lowPhase = (state == ST_LOW_INIT) || (state == ST_LOW);

  always_comb begin
    stateNxt         = state;
    failPendNxt      = failPend;
    doneNxt          = 1'b0;
    failedNxt        = 1'b0;
    strobe.loadTimer = 1'b0;
    strobe.clrPulse  = 1'b0;
    strobe.incPulse  = 1'b0;
    strobe.driveScl  = lowPhase;
    strobe.own       = (state != ST_IDLE);
    case (state)
      ST_IDLE: begin
        if (start) begin
          if (busBusy || !sdaIn) begin
            stateNxt         = ST_LOW_INIT;
            strobe.loadTimer = 1'b1;
            strobe.clrPulse  = 1'b1;
            failPendNxt      = 1'b0;
          end else begin
            doneNxt = 1'b1;
          end
        end
      end
      ST_LOW_INIT, ST_LOW: begin
        if (timerZero) begin
          strobe.loadTimer = 1'b1;
          if (sdaIn) begin
            stateNxt = ST_PARK;
          end else if (pulseMax) begin
            stateNxt    = ST_PARK;
            failPendNxt = 1'b1;
          end else begin
            stateNxt        = ST_HIGH;
            strobe.incPulse = 1'b1;
          end
        end
      end
      ST_HIGH: begin
        if (timerZero) begin
          stateNxt         = ST_LOW;
          strobe.loadTimer = 1'b1;
        end
      end
      ST_PARK: begin
        if (timerZero) begin
          stateNxt  = ST_IDLE;
          doneNxt   = 1'b1;
          failedNxt = failPend;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      failPend <= 1'b0;
      done     <= 1'b0;
      failed   <= 1'b0;
    end else begin
      state    <= stateNxt;
      failPend <= failPendNxt;
      done     <= doneNxt;
      failed   <= failedNxt;
    end
  end

  assign owned = (state != ST_IDLE);

  // R8: done lasts one cycle
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R8: failed only alongside done
  a_r8_fail_with_done: assert property (@(posedge clk) disable iff (!rstN)
    failed |-> done);
  // R7: handing back the pins is always reported
  a_r7_handback_done: assert property (@(posedge clk) disable iff (!rstN)
    $fell(owned) |-> done);
  // R2: a clean-bus request completes at once without taking the pins
  a_r2_clean_request: assert property (@(posedge clk) disable iff (!rstN)
    (start && !owned && !busBusy && sdaIn) |=> (done && !failed && !owned));
  // R5: SDA high at the end of a low phase ends the pulsing
  a_r5_stop_on_release: assert property (@(posedge clk) disable iff (!rstN)
    (lowPhase && timerZero && sdaIn) |=> (state == ST_PARK));
  // R9: a running recovery is not restarted
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    (owned && state != ST_LOW_INIT) |=> (state != ST_LOW_INIT));
endmodule

// File: rtl/i2c_bus_unstick.sv
module i2c_bus_unstick
  import i2c_bus_unstick_pkg::*;
#(
  parameter int HALF_CYC   = 100000,
  parameter int MAX_PULSES = 10
) (
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic busBusy,
  input  logic sdaIn,
  input  logic ctrlSclOe,
  input  logic ctrlSdaOe,
  output logic sclOe,
  output logic sdaOe,
  output logic owned,
  output logic done,
  output logic failed
);
  seqStrobe_t strobe;
  logic       timerZero;
  logic       pulseMax;

  i2c_bus_unstick_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .busBusy   (busBusy),
    .sdaIn     (sdaIn),
    .timerZero (timerZero),
    .pulseMax  (pulseMax),
    .strobe    (strobe),
    .owned     (owned),
    .done      (done),
    .failed    (failed)
  );

  i2c_bus_unstick_dp #(
    .HALF_CYC   (HALF_CYC),
    .MAX_PULSES (MAX_PULSES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .ctrlSclOe (ctrlSclOe),
    .ctrlSdaOe (ctrlSdaOe),
    .timerZero (timerZero),
    .pulseMax  (pulseMax),
    .sclOe     (sclOe),
    .sdaOe     (sdaOe)
  );

  // R3: SDA is never pulled while the sequencer holds the pins
  a_r3_sda_free: assert property (@(posedge clk) disable iff (!rstN)
    owned |-> !sdaOe);
  // R3: the first owned cycle drives SCL low
  a_r3_first_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(owned) |-> sclOe);
endmodule

// File: tb/i2c_bus_unstick_tb.sv
`timescale 1ns/1ps
module i2c_bus_unstick_tb;
  localparam int H = 4;
  localparam int MAXP = 10;
  localparam int NV = 8;
  localparam int VB [NV] = '{1, 0, 0, 1, 0, 0, 0, 0};
  localparam int VK [NV] = '{0, 1, 3, 5, 9, 10, 11, 255};
  localparam int VN [NV] = '{0, 1, 3, 5, 9, 10, 10, 10};
  localparam int VF [NV] = '{0, 0, 0, 0, 0, 0, 1, 1};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, busBusy = 1'b0, ctrlSclOe = 1'b0, ctrlSdaOe = 1'b0;
  logic sdaIn, sclOe, sdaOe, owned, done, failed;
  int checks = 0, errors = 0, cycles = 0;
  int slaveK = 0, relCnt = 0;
  logic prevScl = 1'b1;

  always #2.5 clk = ~clk;

  assign sdaIn = !sdaOe && (relCnt >= slaveK);

  always @(negedge clk) begin
    if (!prevScl && !sclOe) relCnt <= relCnt + 1;
    prevScl <= !sclOe;
  end

  i2c_bus_unstick #(.HALF_CYC(H), .MAX_PULSES(MAXP)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .busBusy(busBusy), .sdaIn(sdaIn),
    .ctrlSclOe(ctrlSclOe), .ctrlSdaOe(ctrlSdaOe), .sclOe(sclOe), .sdaOe(sdaOe),
    .owned(owned), .done(done), .failed(failed));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      finishRun();
    end
  end

  task automatic runRec(int busy, int k, int retrig,
                        output int ownCyc, output int hiCyc,
                        output int sdaBad, output int fl, output int dnAfter);
    int guard = 0;
    slaveK = k;
    relCnt = 0;
    busBusy = busy[0];
    ownCyc = 0; hiCyc = 0; sdaBad = 0; fl = -1;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (!done && guard < 2000) begin
      if (owned) begin
        ownCyc++;
        if (!sclOe) hiCyc++;
        if (sdaOe) sdaBad++;
      end
      start = (ownCyc == retrig);
      guard++;
      @(negedge clk);
    end
    start = 1'b0;
    fl = failed;
    if (owned) sdaBad++;
    @(negedge clk);
    dnAfter = done;
    busBusy = 1'b0;
  endtask

  initial begin
    int ownCyc, hiCyc, sdaBad, fl, dnAfter;
    repeat (3) @(negedge clk);
    chk("R8 reset done", done, 0);
    chk("R8 reset failed", failed, 0);
    chk("R1 reset owned", owned, 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 4; i++) begin
      ctrlSclOe = i[0];
      ctrlSdaOe = i[1];
      #1;
      chk("R1 scl pass", sclOe, i[0]);
      chk("R1 sda pass", sdaOe, i[1]);
      @(negedge clk);
    end
    ctrlSclOe = 1'b0;
    ctrlSdaOe = 1'b0;

    // R2: clean bus request
    slaveK = 0;
    relCnt = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk("R2 done", done, 1);
    chk("R2 failed", failed, 0);
    chk("R2 owned", owned, 0);
    @(negedge clk);
    chk("R2 done single", done, 0);

    // table of recoveries; controller pulls SDA to check R3 override
    ctrlSdaOe = 1'b1;
    for (int v = 0; v < NV; v++) begin
      runRec(VB[v], VK[v], -1, ownCyc, hiCyc, sdaBad, fl, dnAfter);
      chk("R7 owned length", ownCyc, (2 + 2 * VN[v]) * H);
      chk("R4 R6 released cycles", hiCyc, (VN[v] + 1) * H);
      chk("R3 sda released", sdaBad, 0);
      chk("R8 failed flag", fl, VF[v]);
      chk("R8 done single", dnAfter, 0);
      @(negedge clk);
    end

    // R5: slave frees SDA at once, only busy flag set
    runRec(1, 0, -1, ownCyc, hiCyc, sdaBad, fl, dnAfter);
    chk("R5 no pulses", hiCyc, H);

    // R9: retrigger in the middle of a recovery
    runRec(0, 3, 5, ownCyc, hiCyc, sdaBad, fl, dnAfter);
    chk("R9 length unchanged", ownCyc, 8 * H);
    chk("R9 pulses unchanged", hiCyc, 4 * H);

    // R1 after handback
    ctrlSclOe = 1'b1;
    ctrlSdaOe = 1'b0;
    #1;
    chk("R1 scl after handback", sclOe, 1);
    chk("R1 sda after handback", sdaOe, 0);
    finishRun();
  end
endmodule